// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Engine

This block is the arithmetic core of a signal-processing datapath. Each clock it takes two 16-bit operands and multiplies them. Each operand can be read as signed or as unsigned, so the multiplier is a 17x17 signed array. The product is either added to or subtracted from one of two 40-bit accumulators. An accumulator can instead be scaled in place by an arithmetic shift of up to 16 places in either direction. The accumulator is rewritten at the clock edge that ends the operation.

The result is first formed at full precision, wider than the accumulator. Then it is either kept as its low 40 bits or clamped. Clamping goes to one of two ranges: the full 40-bit range, or the signed 32-bit range sign-extended into the guard byte. Two flags per accumulator record whether the unclamped result fell outside the 32-bit range or outside the 40-bit range. Operand fetch, address generation and instruction decode sit outside this block and drive its inputs directly.

Top module: `mac_sat_engine`

## Requirements
- R1: Reset is synchronous and active-low. At a clock edge with `rst_n` low, both accumulators and all four flags become zero, whatever the operation inputs are.
- R2: `op` encodes 2'b00 hold, 2'b01 accumulate (acc + product), 2'b10 deduct (acc - product) and 2'b11 shift. `acc_sel` 0 targets accumulator A and 1 targets accumulator B. Only the targeted accumulator and its flags are updated at the next edge. Hold changes no accumulator and no flag.
- R3: An operand whose sign bit input is 1 is extended with its bit 15. An operand whose sign bit input is 0 is extended with a zero. The 17x17 signed product is sign-extended to the accumulator width.
- R4: With `frac_mode` high, the product is doubled (shifted left one place) before it is combined. 0x8000 x 0x8000, both signed, then contributes 0x0080000000.
- R5: With `sat_en` low, the stored result is the low 40 bits of the exact result (two's-complement wrap).
- R6: With `sat_en` high and `sat_guard` low, an exact result outside the signed 32-bit range is stored as 0x007FFFFFFF if positive or 0xFF80000000 if negative.
- R7: With `sat_en` high and `sat_guard` high, an exact result outside the signed 40-bit range is stored as 0x7FFFFFFFFF or 0x8000000000. Results inside the 40-bit range are stored unchanged.
- R8: `ovf32[i]` is set when the exact result written to accumulator i (bit 0 = A, bit 1 = B) lies outside the signed 32-bit range. `ovf40[i]` is set when it lies outside the signed 40-bit range. Both flags are judged before clamping and are rewritten on every write to that accumulator.
- R9: In shift mode, `shift_amt` is a 6-bit two's-complement count. Positive values shift right arithmetically, filling from bit 39. Negative values shift left. Magnitudes above 16 are treated as 16.
- R10: A shift result goes through the same flag evaluation and the same saturation choice as an accumulate result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op | input | 2 | Operation: hold, accumulate, deduct, shift |
| acc_sel | input | 1 | Target accumulator (0 = A, 1 = B) |
| a_op | input | 16 | First multiplier operand |
| b_op | input | 16 | Second multiplier operand |
| a_signed | input | 1 | First operand is signed |
| b_signed | input | 1 | Second operand is signed |
| frac_mode | input | 1 | Double the product (fractional format) |
| sat_en | input | 1 | Clamp results instead of wrapping |
| sat_guard | input | 1 | Clamp at 40-bit limits rather than 32-bit limits |
| shift_amt | input | 6 | Signed shift count, positive = right |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ovf32 | output | 2 | Per-accumulator 32-bit range overflow flags |
| ovf40 | output | 2 | Per-accumulator 40-bit range overflow flags |

## Verification
The bench targets the fractional product of two most-negative operands. A 16-bit-only multiplier would give a negative value there, and a missing doubling would give half the value. It targets mixed-sign and unsigned-by-unsigned products, where extending with the wrong bit flips the sign of the product or gives a wrong high half. It shifts by counts beyond 16 and shifts negative values right, where an unclamped count or a logical shift would zero or corrupt the accumulator. It also drives results past each limit with saturation off, in 32-bit mode and in 40-bit mode. A design that judged the flags after clamping, or chose the wrong clamp value or sign, would show a wrong flag pair or a wrong stored word.

// File: rtl/mac_pkg.sv
// Package: shared operation encoding for the multiply-accumulate engine.
// Assumes the operation field is two bits wide.
package mac_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'b00,
        OP_ADD   = 2'b01,
        OP_SUB   = 2'b10,
        OP_SHIFT = 2'b11
    } mac_op_e;

endpackage

// File: rtl/mac_mult.sv
// Module: operand extension and product formation.
// Extends each operand to OP_W+1 bits (sign or zero), forms the signed
// product, and doubles it in fractional mode. Purely combinational.
// Assumes the product output is wide enough to hold the doubled
// unsigned-by-unsigned case without loss.
module mac_mult #(
    parameter int OP_W = 16
) (
    input  logic [OP_W-1:0]          a_op,
    input  logic [OP_W-1:0]          b_op,
    input  logic                     a_signed,
    input  logic                     b_signed,
    input  logic                     frac_mode,
    output logic signed [2*OP_W+2:0] prod
);

    localparam int RAW_W  = 2 * OP_W + 2;
    localparam int PROD_W = RAW_W + 1;

    logic signed [OP_W:0]        a_x;
    logic signed [OP_W:0]        b_x;
    logic signed [RAW_W-1:0]     raw;
    logic signed [PROD_W-1:0]    raw_w;

    // Extend operands, multiply, widen and optionally double.
    always_comb begin
        a_x   = {a_signed & a_op[OP_W-1], a_op};
        b_x   = {b_signed & b_op[OP_W-1], b_op};
        raw   = a_x * b_x;
        raw_w = {raw[RAW_W-1], raw};
        prod  = frac_mode ? (raw_w <<< 1) : raw_w;
    end

endmodule

// File: rtl/mac_alu.sv
// Module: wide combine / shift stage.
// Produces the exact (unclamped) result of accumulate, deduct or shift
// in WIDE_W bits, wide enough for a 40-bit value shifted left by
// SHIFT_MAX. Shift count is two's complement; magnitudes past SHIFT_MAX
// are limited to SHIFT_MAX. Purely combinational.
module mac_alu
    import mac_pkg::*;
#(
    parameter int ACC_W     = 40,
    parameter int PROD_W    = 35,
    parameter int SHIFT_MAX = 16,
    parameter int SH_W      = 6,
    parameter int WIDE_W    = 57
) (
    input  logic [ACC_W-1:0]         acc_in,
    input  logic signed [PROD_W-1:0] prod,
    input  mac_op_e                  op,
    input  logic [SH_W-1:0]          shift_amt,
    output logic signed [WIDE_W-1:0] wide
);

    logic signed [WIDE_W-1:0] acc_w;
    logic signed [WIDE_W-1:0] prod_w;
    logic [SH_W-1:0]          mag;
    logic                     go_left;

    // Derive shift direction and limited magnitude.
    always_comb begin
        go_left = shift_amt[SH_W-1];
        mag     = go_left ? (~shift_amt + 1'b1) : shift_amt;
        if (mag > SH_W'(SHIFT_MAX)) begin
            mag = SH_W'(SHIFT_MAX);
        end
    end

    // Form the exact result at full width.
    always_comb begin
        acc_w  = {{(WIDE_W-ACC_W){acc_in[ACC_W-1]}}, acc_in};
        prod_w = {{(WIDE_W-PROD_W){prod[PROD_W-1]}}, prod};
        unique case (op)
            OP_ADD:   wide = acc_w + prod_w;
            OP_SUB:   wide = acc_w - prod_w;
            OP_SHIFT: wide = go_left ? (acc_w <<< mag) : (acc_w >>> mag);
            default:  wide = acc_w;
        endcase
    end

endmodule

// File: rtl/mac_sat.sv
// Module: range check and clamp.
// Flags an exact result outside the signed SAT_W-bit and ACC_W-bit
// ranges, then wraps or clamps it to ACC_W bits. Guard mode clamps at
// the ACC_W limits, normal mode at the SAT_W limits (sign-extended).
// Purely combinational.
module mac_sat #(
    parameter int ACC_W  = 40,
    parameter int SAT_W  = 32,
    parameter int WIDE_W = 57
) (
    input  logic [WIDE_W-1:0] wide,
    input  logic              sat_en,
    input  logic              sat_guard,
    output logic [ACC_W-1:0]  res,
    output logic              ovf32,
    output logic              ovf40
);

    localparam logic [ACC_W-1:0] MAX_FULL = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] MIN_FULL = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic [ACC_W-1:0] MAX_NORM = {{(ACC_W-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] MIN_NORM = {{(ACC_W-SAT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};

    logic fit_full;
    logic fit_norm;
    logic neg;

    // Range tests: all bits from the limit's sign position upward agree.
    always_comb begin
        fit_full = (&wide[WIDE_W-1:ACC_W-1]) | ~(|wide[WIDE_W-1:ACC_W-1]);
        fit_norm = (&wide[WIDE_W-1:SAT_W-1]) | ~(|wide[WIDE_W-1:SAT_W-1]);
        neg      = wide[WIDE_W-1];
        ovf40    = ~fit_full;
        ovf32    = ~fit_norm;
    end

    // Select wrapped or clamped result.
    always_comb begin
        res = wide[ACC_W-1:0];
        if (sat_en) begin
            if (sat_guard) begin
                if (!fit_full) res = neg ? MIN_FULL : MAX_FULL;
            end else begin
                if (!fit_norm) res = neg ? MIN_NORM : MAX_NORM;
            end
        end
    end

endmodule

// File: rtl/mac_sat_engine.sv
// Module: top of the saturating multiply-accumulate engine.
// One shared product/combine/clamp path feeds two accumulator banks;
// the bank named by acc_sel is rewritten at the edge ending a non-hold
// operation. Assumes inputs are stable around the rising edge.
module mac_sat_engine
    import mac_pkg::*;
#(
    parameter int OP_W      = 16,
    parameter int GUARD_W   = 8,
    parameter int SHIFT_MAX = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [1:0]                      op,
    input  logic                            acc_sel,
    input  logic [OP_W-1:0]                 a_op,
    input  logic [OP_W-1:0]                 b_op,
    input  logic                            a_signed,
    input  logic                            b_signed,
    input  logic                            frac_mode,
    input  logic                            sat_en,
    input  logic                            sat_guard,
    input  logic [$clog2(SHIFT_MAX)+1:0]    shift_amt,
    output logic [GUARD_W+2*OP_W-1:0]       acc_a,
    output logic [GUARD_W+2*OP_W-1:0]       acc_b,
    output logic [1:0]                      ovf32,
    output logic [1:0]                      ovf40
);

    localparam int SAT_W   = 2 * OP_W;
    localparam int ACC_W   = GUARD_W + SAT_W;
    localparam int PROD_W  = 2 * OP_W + 3;
    localparam int SH_W    = $clog2(SHIFT_MAX) + 2;
    localparam int WIDE_W  = ACC_W + SHIFT_MAX + 1;
    localparam int NUM_ACC = 2;

    mac_op_e                  op_e;
    logic signed [PROD_W-1:0] prod;
    logic [ACC_W-1:0]         acc_cur;
    logic signed [WIDE_W-1:0] wide;
    logic [ACC_W-1:0]         res;
    logic                     res_o32;
    logic                     res_o40;

    logic [ACC_W-1:0]         acc_r [NUM_ACC];
    logic                     o32_r [NUM_ACC];
    logic                     o40_r [NUM_ACC];

    // Decode the operation field and pick the source accumulator.
    always_comb begin
        op_e    = mac_op_e'(op);
        acc_cur = acc_sel ? acc_r[1] : acc_r[0];
    end

    mac_mult #(.OP_W(OP_W)) u_mult (
        .a_op      (a_op),
        .b_op      (b_op),
        .a_signed  (a_signed),
        .b_signed  (b_signed),
        .frac_mode (frac_mode),
        .prod      (prod)
    );

    mac_alu #(
        .ACC_W     (ACC_W),
        .PROD_W    (PROD_W),
        .SHIFT_MAX (SHIFT_MAX),
        .SH_W      (SH_W),
        .WIDE_W    (WIDE_W)
    ) u_alu (
        .acc_in    (acc_cur),
        .prod      (prod),
        .op        (op_e),
        .shift_amt (shift_amt),
        .wide      (wide)
    );

    mac_sat #(
        .ACC_W  (ACC_W),
        .SAT_W  (SAT_W),
        .WIDE_W (WIDE_W)
    ) u_sat (
        .wide      (wide),
        .sat_en    (sat_en),
        .sat_guard (sat_guard),
        .res       (res),
        .ovf32     (res_o32),
        .ovf40     (res_o40)
    );

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
        // Write result and flags into this bank when it is targeted.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_r[g] <= '0;
                o32_r[g] <= 1'b0;
                o40_r[g] <= 1'b0;
            end else if (op_e != OP_HOLD && acc_sel == 1'(g)) begin
                acc_r[g] <= res;
                o32_r[g] <= res_o32;
                o40_r[g] <= res_o40;
            end
        end
    end

    // Drive the outputs from the banks.
    always_comb begin
        acc_a = acc_r[0];
        acc_b = acc_r[1];
        ovf32 = {o32_r[1], o32_r[0]};
        ovf40 = {o40_r[1], o40_r[0]};
    end

    // R1: a reset edge clears everything.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (acc_a == '0 && acc_b == '0 && ovf32 == 2'b00 && ovf40 == 2'b00));

    // R2: hold leaves all state untouched.
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b00) |=> ($stable(acc_a) && $stable(acc_b) && $stable(ovf32) && $stable(ovf40)));

    // R2: targeting B leaves A alone.
    assert_unsel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op != 2'b00 && acc_sel) |=> ($stable(acc_a) && $stable(ovf32[0]) && $stable(ovf40[0])));

    // R6: normal saturation keeps A inside the 32-bit range.
    assert_norm_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op != 2'b00 && !acc_sel && sat_en && !sat_guard)
        |=> ((&acc_a[ACC_W-1:SAT_W-1]) || !(|acc_a[ACC_W-1:SAT_W-1])));

    // R8: a 40-bit overflow is always also a 32-bit overflow.
    assert_flag_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf40 & ~ovf32) == 2'b00);

endmodule

// File: tb/mac_sat_engine_tb.sv
`timescale 1ns/1ps
module mac_sat_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  op;
    logic        acc_sel;
    logic [15:0] a_op, b_op;
    logic        a_signed, b_signed, frac_mode, sat_en, sat_guard;
    logic [5:0]  shift_amt;
    logic [39:0] acc_a, acc_b;
    logic [1:0]  ovf32, ovf40;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    mac_sat_engine u_dut (
        .clk(clk), .rst_n(rst_n), .op(op), .acc_sel(acc_sel),
        .a_op(a_op), .b_op(b_op), .a_signed(a_signed), .b_signed(b_signed),
        .frac_mode(frac_mode), .sat_en(sat_en), .sat_guard(sat_guard),
        .shift_amt(shift_amt), .acc_a(acc_a), .acc_b(acc_b),
        .ovf32(ovf32), .ovf40(ovf40)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic        sel;
        logic [15:0] a;
        logic [15:0] b;
        logic        as;
        logic        bs;
        logic        frac;
        logic        sat;
        logic        grd;
        logic [5:0]  sh;
        logic [39:0] e_acc;
        logic        e32;
        logic        e40;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{2'd1,1'b0,16'h0003,16'hFFFE,1'b1,1'b1,1'b0,1'b0,1'b0,6'h00,40'hFFFFFFFFFA,1'b0,1'b0,4'd3},  // R3 signed x signed
        '{2'd1,1'b0,16'hFFFF,16'hFFFF,1'b0,1'b0,1'b0,1'b0,1'b0,6'h00,40'h00FFFDFFFB,1'b1,1'b0,4'd3},  // R3 unsigned x unsigned, R8
        '{2'd2,1'b0,16'hFFFF,16'hFFFF,1'b1,1'b0,1'b0,1'b0,1'b0,6'h00,40'h00FFFEFFFA,1'b1,1'b0,4'd2},  // R2 deduct, mixed sign
        '{2'd1,1'b1,16'h8000,16'h8000,1'b1,1'b1,1'b1,1'b0,1'b0,6'h00,40'h0080000000,1'b1,1'b0,4'd4},  // R4 (-1)x(-1)
        '{2'd1,1'b1,16'h8000,16'h8000,1'b1,1'b1,1'b1,1'b1,1'b0,6'h00,40'h007FFFFFFF,1'b1,1'b0,4'd6},  // R6 positive clamp
        '{2'd2,1'b1,16'h7FFF,16'h7FFF,1'b1,1'b1,1'b0,1'b1,1'b0,6'h00,40'h004000FFFE,1'b0,1'b0,4'd2},  // R2 deduct on B
        '{2'd0,1'b0,16'h1234,16'h5678,1'b1,1'b1,1'b1,1'b1,1'b1,6'h05,40'h00FFFEFFFA,1'b1,1'b0,4'd2},  // R2 hold
        '{2'd3,1'b0,16'h0000,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0,6'h04,40'h000FFFEFFF,1'b0,1'b0,4'd9},  // R9 right 4
        '{2'd3,1'b0,16'h0000,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0,6'h30,40'hFFEFFF0000,1'b1,1'b1,4'd5},  // R5 left 16 wraps
        '{2'd3,1'b0,16'h0000,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0,6'h1F,40'hFFFFFFEFFF,1'b0,1'b0,4'd9},  // R9 count 31 -> 16, sign fill
        '{2'd3,1'b0,16'h0000,16'h0000,1'b0,1'b0,1'b0,1'b1,1'b1,6'h20,40'hFFEFFF0000,1'b0,1'b0,4'd9},  // R9 count -32 -> -16
        '{2'd3,1'b0,16'h0000,16'h0000,1'b0,1'b0,1'b0,1'b1,1'b1,6'h30,40'h8000000000,1'b1,1'b1,4'd7},  // R7 guard clamp on shift
        '{2'd1,1'b0,16'h0001,16'h0001,1'b1,1'b1,1'b0,1'b1,1'b0,6'h00,40'hFF80000000,1'b1,1'b0,4'd6},  // R6 negative clamp
        '{2'd3,1'b1,16'h0000,16'h0000,1'b0,1'b0,1'b0,1'b0,1'b0,6'h37,40'h8001FFFC00,1'b1,1'b1,4'd5},  // R5 left 9 wraps
        '{2'd3,1'b1,16'h0000,16'h0000,1'b0,1'b0,1'b0,1'b1,1'b0,6'h00,40'hFF80000000,1'b1,1'b0,4'd10}, // R10 shift then clamp
        '{2'd1,1'b1,16'h0002,16'h0003,1'b0,1'b0,1'b1,1'b1,1'b1,6'h00,40'hFF8000000C,1'b0,1'b0,4'd4},  // R4 fractional unsigned
        '{2'd1,1'b0,16'hFFFF,16'hFFFF,1'b1,1'b1,1'b1,1'b0,1'b0,6'h00,40'hFF80000002,1'b0,1'b0,4'd3}   // R3 (-1)x(-1) tiny
    };

    logic [39:0] exp_acc [2];
    logic [1:0]  exp32, exp40;

    task automatic check40(input string tag, input string what, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check2(input string tag, input string what, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check40(tag, "acc_a", acc_a, exp_acc[0]);
        check40(tag, "acc_b", acc_b, exp_acc[1]);
        check2(tag, "ovf32", ovf32, exp32);
        check2(tag, "ovf40", ovf40, exp40);
    endtask

    task automatic drive(input vec_t v);
        op = v.op; acc_sel = v.sel; a_op = v.a; b_op = v.b;
        a_signed = v.as; b_signed = v.bs; frac_mode = v.frac;
        sat_en = v.sat; sat_guard = v.grd; shift_amt = v.sh;
    endtask

    initial begin
        rst_n = 1'b0;
        drive('0);
        exp_acc[0] = '0; exp_acc[1] = '0; exp32 = '0; exp40 = '0;
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 reset");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(posedge clk);
            #1;
            exp_acc[VECS[i].sel] = VECS[i].e_acc;
            exp32[VECS[i].sel]   = VECS[i].e32;
            exp40[VECS[i].sel]   = VECS[i].e40;
            check_all($sformatf("R%0d vector %0d", VECS[i].req, i));
        end

        // R1: reset wins over an active accumulate.
        drive('{2'd1,1'b0,16'h4000,16'h4000,1'b1,1'b1,1'b0,1'b0,1'b0,6'h00,40'h0,1'b0,1'b0,4'd1});
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        exp_acc[0] = '0; exp_acc[1] = '0; exp32 = '0; exp40 = '0;
        check_all("R1 reset over op");
        rst_n = 1'b1;

        // R7: guard mode leaves a 32-bit overflow unclamped; R2: A untouched.
        drive('{2'd1,1'b1,16'h8000,16'h8000,1'b1,1'b1,1'b1,1'b1,1'b1,6'h00,40'h0,1'b0,1'b0,4'd7});
        @(posedge clk);
        #1;
        exp_acc[1] = 40'h0080000000; exp32 = 2'b10; exp40 = 2'b00;
        check_all("R7 guard no clamp");

        // R2: hold after the write keeps everything.
        drive('0);
        repeat (2) @(posedge clk);
        #1;
        check_all("R2 hold");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule